// File: doc/BRIEF.md
# Double-Buffered Input Capture Channel

This block timestamps transitions on one external input. The input passes through a two-flop synchronizer. A two-bit mode field then decides which transitions count as events: none, rising, falling, or both. On each qualifying event, the value of an external 16-bit free-running timer is latched into a one-entry holding buffer. The buffer feeds a readable event-time register. A held value moves into that register in the first cycle the register is empty. Each such move raises a one-cycle `pend` pulse.

Software or a consumer reads the register by pulsing `rd_strobe` while `evt_valid` is high, and this empties the register. An event that arrives while both the register and the buffer are occupied is dropped, and the channel raises a one-cycle `ovr` pulse. The block has no mask input, so both pulses always appear and can be polled or collected by an interrupt controller outside the block. The timer and the interrupt logic are not part of this block.

Top module: `cap_chan`

## Requirements
- R1: While `rst` is high, and on the first sampled cycle after it, `evt_valid`, `pend` and `ovr` are 0.
- R2: `edge_mode` selects the events. 2'b00 means no event, 2'b01 a 0-to-1 transition, 2'b10 a 1-to-0 transition and 2'b11 either transition. Non-selected transitions capture nothing.
- R3: Suppose `sig_in` holds a new level at clock edge k, with the buffer and the register both empty. Then the timer value present at edge k+2 is captured. It is visible on `evt_time`, with `evt_valid` high, after edge k+3.
- R4: The `pend` output is a one-cycle pulse. It is high exactly in the cycles where `evt_valid` has just risen because a buffered time moved into the register.
- R5: Take a `rd_strobe` while `evt_valid` is high. `evt_valid` is low in the following cycle. A `rd_strobe` while `evt_valid` is low changes nothing. Without a read, `evt_valid` and `evt_time` hold.
- R6: If the buffer holds a time when the register is read, that time appears on `evt_time` one cycle after `evt_valid` drops. A `pend` pulse accompanies it.
- R7: Take an event while the register is full and the buffer is full and not moving. The channel drops the new time and pulses `ovr` for one cycle, and it keeps the buffered time. `pend` and `ovr` are never high together.
- R8: Take an event in the same cycle the buffered time moves into the register. The buffer accepts the event and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Asynchronous input to timestamp |
| timer_val | input | TW (16) | Free-running timer value |
| edge_mode | input | 2 | Event selection: 00 off, 01 rise, 10 fall, 11 both |
| rd_strobe | input | 1 | Read of the event-time register; empties it |
| evt_time | output | TW (16) | Event-time register contents |
| evt_valid | output | 1 | Event-time register holds an unread time |
| pend | output | 1 | One-cycle pulse on each buffer-to-register move |
| ovr | output | 1 | One-cycle pulse when an event is dropped |

## Verification
The hardest case to reach is R8. A read must land exactly one cycle before an event leaves the synchronizer, so that the buffer drains into the register on the same edge that a new capture arrives. The stimulus first fills the register and the buffer. It then toggles the input and issues the read on the next cycle. The reference model decides whether the new time is kept or dropped. A long random phase mixes modes, toggles and reads, and it repeatedly reaches overruns and back-to-back transfers.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sig_in,
  input  logic [1:0] edge_mode,
  output logic       event_hit
);
  import cap_pkg::*;

  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= sig_in;
  end

  genvar i;
  generate
    for (i = 1; i < CHAIN_W; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  endgenerate

  logic level_now, level_old;
  assign level_now = chain[SYNC_STAGES-1];
  assign level_old = chain[SYNC_STAGES];

  always_comb begin
    case (edge_mode_e'(edge_mode))
      EDGE_RISE: event_hit = level_now & ~level_old;
      EDGE_FALL: event_hit = ~level_now & level_old;
      EDGE_ANY:  event_hit = level_now ^ level_old;
      default:   event_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/cap_store.sv
module cap_store #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          event_hit,
  input  logic [TW-1:0] timer_val,
  input  logic          rd_strobe,
  output logic [TW-1:0] evt_time,
  output logic          evt_valid,
  output logic          pend,
  output logic          ovr
);
  logic [TW-1:0] hold_q;
  logic          hold_full;
  logic          move;
  logic          slot_free;

  assign move      = hold_full & ~evt_valid;
  assign slot_free = ~hold_full | move;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
    end else if (event_hit && slot_free) begin
      hold_full <= 1'b1;
      hold_q    <= timer_val;
    end else if (move) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_valid <= 1'b0;
      evt_time  <= '0;
    end else if (move) begin
      evt_valid <= 1'b1;
      evt_time  <= hold_q;
    end else if (rd_strobe) begin
      evt_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      pend <= move;
      ovr  <= event_hit & ~slot_free;
    end
  end
endmodule

// File: rtl/cap_chan.sv
module cap_chan #(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sig_in,
  input  logic [TW-1:0] timer_val,
  input  logic [1:0]    edge_mode,
  input  logic          rd_strobe,
  output logic [TW-1:0] evt_time,
  output logic          evt_valid,
  output logic          pend,
  output logic          ovr
);
  logic event_hit;

  cap_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk       (clk),
    .rst       (rst),
    .sig_in    (sig_in),
    .edge_mode (edge_mode),
    .event_hit (event_hit)
  );

  cap_store #(.TW(TW)) u_store (
    .clk       (clk),
    .rst       (rst),
    .event_hit (event_hit),
    .timer_val (timer_val),
    .rd_strobe (rd_strobe),
    .evt_time  (evt_time),
    .evt_valid (evt_valid),
    .pend      (pend),
    .ovr       (ovr)
  );
endmodule

// File: rtl/cap_chan_chk.sv
module cap_chan_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_strobe,
  input logic [TW-1:0] evt_time,
  input logic          evt_valid,
  input logic          pend,
  input logic          ovr
);
  // R4: a pulse on pend means the register was just filled
  a_r4_pend_valid: assert property (@(posedge clk) disable iff (rst)
    pend |-> evt_valid);
  a_r4_pend_fresh: assert property (@(posedge clk) disable iff (rst)
    pend |-> !$past(evt_valid));
  a_r4_rise_pend: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_valid) |-> pend);
  // R5: read empties, no read holds
  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && evt_valid) |=> !evt_valid);
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!rd_strobe && evt_valid) |=> (evt_valid && $stable(evt_time)));
  // R7: overrun only with a full register, never with pend
  a_r7_ovr_full: assert property (@(posedge clk) disable iff (rst)
    ovr |-> $past(evt_valid));
  a_r7_not_both: assert property (@(posedge clk) disable iff (rst)
    !(pend && ovr));
endmodule

bind cap_chan cap_chan_chk #(.TW(TW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_strobe (rd_strobe),
  .evt_time  (evt_time),
  .evt_valid (evt_valid),
  .pend      (pend),
  .ovr       (ovr)
);

// File: tb/cap_chan_test.sv
module cap_chan_test;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sig_in = 1'b0;
  logic [TW-1:0] timer_val = '0;
  logic [1:0]    edge_mode = 2'b00;
  logic          rd_strobe = 1'b0;
  logic [TW-1:0] evt_time;
  logic          evt_valid;
  logic          pend;
  logic          ovr;

  int checks = 0;
  int fails  = 0;
  int pcnt = 0;
  int ocnt = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) timer_val <= timer_val + 1'b1;

  cap_chan #(.TW(TW)) uut (
    .clk(clk), .rst(rst), .sig_in(sig_in), .timer_val(timer_val),
    .edge_mode(edge_mode), .rd_strobe(rd_strobe), .evt_time(evt_time),
    .evt_valid(evt_valid), .pend(pend), .ovr(ovr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit            hist[$];
  bit            m_hf, m_rf, m_pend, m_ovr;
  int            m_hold, m_reg;

  always @(posedge clk) begin
    if (rst) begin
      hist = '{1'b0, 1'b0, 1'b0};
      m_hf = 0; m_rf = 0; m_pend = 0; m_ovr = 0; m_hold = 0; m_reg = 0;
    end else begin
      bit now_l, old_l, ev, mv, free;
      now_l = hist[$-1];
      old_l = hist[$-2];
      case (edge_mode)
        2'b01:   ev = now_l && !old_l;
        2'b10:   ev = !now_l && old_l;
        2'b11:   ev = now_l != old_l;
        default: ev = 0;
      endcase
      mv   = m_hf && !m_rf;
      free = !m_hf || mv;
      m_pend = mv;
      m_ovr  = ev && !free;
      if (mv) begin m_reg = m_hold; m_rf = 1; end
      else if (rd_strobe) m_rf = 0;
      if (ev && free) begin m_hold = int'(timer_val); m_hf = 1; end
      else if (mv) m_hf = 0;
      hist.push_back(sig_in);
      void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (pend) pcnt++;
      if (ovr)  ocnt++;
      check(evt_valid == m_rf, "R6 evt_valid vs model", evt_valid, m_rf);
      if (m_rf) check(int'(evt_time) == m_reg, "R3 evt_time vs model", evt_time, m_reg);
      check(pend == m_pend, "R4 pend vs model", pend, m_pend);
      check(ovr == m_ovr, "R7 ovr vs model", ovr, m_ovr);
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic drain();
    tick(6);
    for (int i = 0; i < 8; i++) begin
      rd_strobe = evt_valid;
      tick();
    end
    rd_strobe = 0;
  endtask

  task automatic pulse_phase(input logic [1:0] mode, input int exp, input string tag);
    int p0;
    edge_mode = mode;
    p0 = pcnt;
    sig_in = 1; tick(6); rd_strobe = evt_valid; tick(); rd_strobe = 0;
    sig_in = 0; drain();
    check(pcnt - p0 == exp, tag, pcnt - p0, exp);
  endtask

  initial begin
    int t0, p0, o0;
    tick(3);
    check(evt_valid == 0 && pend == 0 && ovr == 0, "R1 reset outputs", {evt_valid, pend, ovr}, 0);
    rst = 0;
    tick();
    check(evt_valid == 0 && pend == 0 && ovr == 0, "R1 after reset", {evt_valid, pend, ovr}, 0);

    pulse_phase(2'b00, 0, "R2 mode off");
    pulse_phase(2'b01, 1, "R2 mode rise");
    pulse_phase(2'b10, 1, "R2 mode fall");
    pulse_phase(2'b11, 2, "R2 mode both");

    // R3 latency with both stages empty
    edge_mode = 2'b01;
    t0 = int'(timer_val);
    sig_in = 1;
    tick(3);
    check(evt_valid == 0, "R3 not yet visible", evt_valid, 0);
    tick();
    check(evt_valid == 1, "R3 visible", evt_valid, 1);
    check(int'(evt_time) == ((t0 + 2) & 16'hFFFF), "R3 captured time", evt_time, (t0 + 2) & 16'hFFFF);
    check(pend == 1, "R4 pend with transfer", pend, 1);
    tick();
    check(pend == 0, "R4 pend one cycle", pend, 0);
    tick(3);
    check(evt_valid == 1, "R5 hold without read", evt_valid, 1);
    rd_strobe = 1; tick(); rd_strobe = 0;
    check(evt_valid == 0, "R5 read clears", evt_valid, 0);
    rd_strobe = 1; tick(); rd_strobe = 0;
    check(evt_valid == 0 && pend == 0, "R5 read when empty ignored", {evt_valid, pend}, 0);
    sig_in = 0; tick(4);

    // R6 / R7: fill register, buffer, then overrun
    edge_mode = 2'b11;
    o0 = ocnt;
    sig_in = 1; tick(4);
    t0 = int'(timer_val);
    sig_in = 0; tick(4);
    sig_in = 1; tick(4);
    check(ocnt - o0 == 1, "R7 overrun counted", ocnt - o0, 1);
    rd_strobe = 1; tick(); rd_strobe = 0;
    check(evt_valid == 0, "R6 drop after read", evt_valid, 0);
    tick();
    check(evt_valid == 1 && pend == 1, "R6 buffered value moves", {evt_valid, pend}, 3);
    check(int'(evt_time) == ((t0 + 2) & 16'hFFFF), "R7 kept buffered time", evt_time, (t0 + 2) & 16'hFFFF);

    // R8: refill buffer, then read so the transfer meets a new event
    sig_in = 0; tick(5);
    check(evt_valid == 1, "R8 register full", evt_valid, 1);
    o0 = ocnt; p0 = pcnt;
    sig_in = 1; tick();
    rd_strobe = 1; tick(); rd_strobe = 0;
    tick(3);
    check(ocnt - o0 == 0, "R8 no overrun on transfer edge", ocnt - o0, 0);
    check(pcnt - p0 == 1, "R8 one transfer", pcnt - p0, 1);
    rd_strobe = 1; tick(); rd_strobe = 0;
    tick();
    check(pend == 1, "R8 accepted event transfers", pend, 1);
    drain();
    sig_in = 0; drain();

    // random phase
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 3) == 0) sig_in = ~sig_in;
      if ($urandom_range(0, 99) == 0) edge_mode = 2'($urandom_range(0, 3));
      rd_strobe = ($urandom_range(0, 4) == 0);
      tick();
    end
    rd_strobe = 0;
    tick(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule